// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Compare

This block keeps the time of day as a count of seconds. Each pulse on a one-per-second tick input advances the count by one. After the last second of a day the count returns to zero. A second register holds an alarm value. When a tick moves the count onto the alarm value, the block issues a one-clock chime strobe. If the wake enable is set, it also issues a one-clock request to the system's reset-pulse generator, so the alarm can bring the system out of standby.

Software reaches three locations through a flat register port: the time count, the alarm value and a control word. Read data is combinational from the address. One alarm value is reserved as a disable code, and it is also the value the alarm register takes at reset, so the alarm stays silent until software programs it. A write to the time count wins over a tick that arrives in the same cycle. The counting phase therefore restarts from the written value.

Top module: `tod_alarm_core`

## Requirements
- R1: After reset the time count reads 0, the alarm reads 0x0FFFF, the control word reads 0, and chime_o and wake_req_o are low.
- R2: A tick with no time write in the same cycle raises the time count by exactly one, visible one clock later.
- R3: A tick when the count is 86399 or greater sets the count to 0. This covers values above 86399 written by software.
- R4: Address 0 selects the time count, address 1 the alarm and address 2 the control word, whose bit 0 is the wake enable. rdata_o shows the selected register zero-extended in the same cycle. Address 3 reads 0, and writes to it change nothing.
- R5: A write to address 0 loads the count one clock later, and a tick in the same cycle is discarded.
- R6: chime_o is high for exactly the one clock after the edge at which a tick moves the count onto the alarm value.
- R7: While the alarm holds 0x0FFFF no chime is produced, even when the count steps onto 65535.
- R8: wake_req_o pulses in the same clock as chime_o when control bit 0 is set, and stays low when it is clear.
- R9: A match is detected only on a tick. Writing an alarm equal to the current count, or writing the count equal to the alarm, produces no chime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 17 | Write data |
| rdata_o | output | 17 | Read data for addr_i |
| chime_o | output | 1 | Alarm match strobe |
| wake_req_o | output | 1 | Reset-pulse request on alarm match |

## Verification
Every registered result (the new count, the chime and the wake request) becomes visible one clock after the edge that samples the tick or write. Read data follows the address combinationally in that same settled cycle. The bench drives inputs 1 ns after a rising edge and updates its model for that edge. It then checks every output 1 ns after the next rising edge, so each expectation is compared in the one cycle it belongs to. Random ticks and writes are mixed with directed cases: the wrap, the disable code, a coincident write and tick, and matches caused by writes.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        REG_TIME  = 2'd0,
        REG_ALARM = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } tod_addr_e;
endpackage

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int TIME_W      = 17,
    parameter int SEC_PER_DAY = 86400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [TIME_W-1:0] load_val_i,
    output logic [TIME_W-1:0] count_o,
    output logic [TIME_W-1:0] next_o,
    output logic              advance_o
);
    localparam logic [TIME_W-1:0] LAST_SEC = TIME_W'(SEC_PER_DAY - 1);

    typedef struct packed {
        logic [TIME_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [TIME_W-1:0] inc_d;
    logic              adv_d;

    always_comb begin
        st_d  = st_q;
        adv_d = tick_i && !load_i;
        inc_d = (st_q.count >= LAST_SEC) ? '0 : st_q.count + 1'b1;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (tick_i) begin
            st_d.count = inc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign next_o    = inc_d;
    assign advance_o = adv_d;

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o < LAST_SEC) |=> count_o == $past(count_o) + 1'b1);
    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o >= LAST_SEC) |=> count_o == '0);
    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
    import tod_pkg::*;
#(
    parameter int               TIME_W    = 17,
    parameter logic [TIME_W-1:0] ALARM_OFF = 17'h0FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [TIME_W-1:0] wdata_i,
    input  logic [TIME_W-1:0] count_i,
    output logic [TIME_W-1:0] alarm_o,
    output logic              wake_en_o,
    output logic [TIME_W-1:0] rdata_o
);
    typedef struct packed {
        logic [TIME_W-1:0] alarm;
        logic              wake_en;
    } reg_state_t;

    reg_state_t st_d, st_q;
    tod_addr_e  sel;

    always_comb begin
        sel  = tod_addr_e'(addr_i);
        st_d = st_q;
        if (wr_en_i) begin
            case (sel)
                REG_ALARM: st_d.alarm   = wdata_i;
                REG_CTRL:  st_d.wake_en = wdata_i[0];
                default:   st_d = st_q;
            endcase
        end
        case (sel)
            REG_TIME:  rdata_o = count_i;
            REG_ALARM: rdata_o = st_q.alarm;
            REG_CTRL:  rdata_o = {{(TIME_W-1){1'b0}}, st_q.wake_en};
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.alarm   <= ALARM_OFF;
            st_q.wake_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o   = st_q.alarm;
    assign wake_en_o = st_q.wake_en;

    assert_alarm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == 2'd1) |=> $stable(alarm_o));
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == 2'd2) |=> $stable(wake_en_o));
endmodule

// File: rtl/tod_match.sv
module tod_match #(
    parameter int               TIME_W    = 17,
    parameter logic [TIME_W-1:0] ALARM_OFF = 17'h0FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic [TIME_W-1:0] next_i,
    input  logic [TIME_W-1:0] alarm_i,
    input  logic              wake_en_i,
    output logic              chime_o,
    output logic              wake_o
);
    typedef struct packed {
        logic chime;
        logic wake;
    } hit_state_t;

    hit_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit        = advance_i && (next_i == alarm_i) && (alarm_i != ALARM_OFF);
        st_d.chime = hit;
        st_d.wake  = hit && wake_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chime_o = st_q.chime;
    assign wake_o  = st_q.wake;

    assert_wake_with_chime_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (chime_o && $past(wake_en_i)));
    assert_off_code_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chime_o |-> ($past(alarm_i) != ALARM_OFF));
    assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chime_o |-> $past(advance_i));
endmodule

// File: rtl/tod_alarm_core.sv
module tod_alarm_core
    import tod_pkg::*;
#(
    parameter int               TIME_W      = 17,
    parameter int               SEC_PER_DAY = 86400,
    parameter logic [TIME_W-1:0] ALARM_OFF   = 17'h0FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [TIME_W-1:0] wdata_i,
    output logic [TIME_W-1:0] rdata_o,
    output logic              chime_o,
    output logic              wake_req_o
);
    logic              load_time;
    logic [TIME_W-1:0] count;
    logic [TIME_W-1:0] next_count;
    logic              advance;
    logic [TIME_W-1:0] alarm;
    logic              wake_en;

    assign load_time = wr_en_i && (tod_addr_e'(addr_i) == REG_TIME);

    tod_counter #(
        .TIME_W      (TIME_W),
        .SEC_PER_DAY (SEC_PER_DAY)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load_time),
        .load_val_i (wdata_i),
        .count_o    (count),
        .next_o     (next_count),
        .advance_o  (advance)
    );

    tod_regfile #(
        .TIME_W    (TIME_W),
        .ALARM_OFF (ALARM_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .count_i   (count),
        .alarm_o   (alarm),
        .wake_en_o (wake_en),
        .rdata_o   (rdata_o)
    );

    tod_match #(
        .TIME_W    (TIME_W),
        .ALARM_OFF (ALARM_OFF)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .next_i    (next_count),
        .alarm_i   (alarm),
        .wake_en_i (wake_en),
        .chime_o   (chime_o),
        .wake_o    (wake_req_o)
    );
endmodule

// File: tb/tod_alarm_core_tb.sv
module tod_alarm_core_tb;
    localparam int          TW    = 17;
    localparam logic [16:0] OFF   = 17'h0FFFF;
    localparam logic [16:0] LASTS = 17'd86399;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [TW-1:0] wdata = '0;
    logic [TW-1:0] rdata;
    logic          chime;
    logic          wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [16:0] m_time  = '0;
    logic [16:0] m_alarm = OFF;
    logic        m_en    = 1'b0;

    always #4 clk = ~clk;

    tod_alarm_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .chime_o    (chime),
        .wake_req_o (wake)
    );

    function automatic logic [16:0] next_time(input logic [16:0] t);
        return (t >= LASTS) ? 17'd0 : t + 17'd1;
    endfunction

    function automatic logic [16:0] read_exp(input logic [1:0] a);
        case (a)
            2'd0:    return m_time;
            2'd1:    return m_alarm;
            2'd2:    return {16'd0, m_en};
            default: return 17'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic tk, input logic wr, input logic [1:0] a,
                        input logic [16:0] d, input string req);
        logic ech;
        logic ewk;
        logic [16:0] nt;
        tick = tk; wr_en = wr; addr = a; wdata = d;
        ech = 1'b0; ewk = 1'b0;
        if (wr && a == 2'd0) begin
            m_time = d;
        end else if (tk) begin
            nt  = next_time(m_time);
            ech = (nt == m_alarm) && (m_alarm != OFF);
            ewk = ech && m_en;
            m_time = nt;
        end
        if (wr && a == 2'd1) m_alarm = d;
        if (wr && a == 2'd2) m_en = d[0];
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
        check({req, " chime"}, {16'd0, chime}, {16'd0, ech});
        check({req, " wake"},  {16'd0, wake},  {16'd0, ewk});
        check({req, " rdata"}, rdata, read_exp(a));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values through the read port
        addr = 2'd0; #1 check("R1 time", rdata, 17'd0);
        addr = 2'd1; #1 check("R1 alarm", rdata, OFF);
        addr = 2'd2; #1 check("R1 ctrl", rdata, 17'd0);
        check("R1 chime", {16'd0, chime}, 17'd0);
        check("R1 wake", {16'd0, wake}, 17'd0);
        // R2 plain counting
        repeat (5) step(1'b1, 1'b0, 2'd0, 17'd0, "R2");
        // R7 disable code: count steps onto 65535 with reset alarm
        step(1'b0, 1'b1, 2'd0, 17'd65533, "R5");
        repeat (3) step(1'b1, 1'b0, 2'd0, 17'd0, "R7");
        // R3 wrap at end of day and from out-of-range values
        step(1'b0, 1'b1, 2'd0, 17'd86398, "R5");
        repeat (2) step(1'b1, 1'b0, 2'd0, 17'd0, "R3");
        step(1'b0, 1'b1, 2'd0, 17'h1FFFF, "R5");
        step(1'b1, 1'b0, 2'd0, 17'd0, "R3");
        // R4 unused address: write ignored, reads zero
        step(1'b0, 1'b1, 2'd3, 17'h1ABCD, "R4");
        step(1'b0, 1'b0, 2'd1, 17'd0, "R4");
        step(1'b0, 1'b0, 2'd2, 17'd0, "R4");
        // R5 coincident write and tick: tick discarded
        step(1'b1, 1'b1, 2'd0, 17'd100, "R5");
        step(1'b0, 1'b0, 2'd0, 17'd0, "R5");
        // R6 match without wake enable
        step(1'b0, 1'b1, 2'd1, 17'd103, "R4");
        repeat (4) step(1'b1, 1'b0, 2'd0, 17'd0, "R6");
        // R8 match with wake enable
        step(1'b0, 1'b1, 2'd2, 17'd1, "R8");
        step(1'b0, 1'b1, 2'd0, 17'd101, "R5");
        repeat (3) step(1'b1, 1'b0, 2'd0, 17'd0, "R8");
        // R9 writes that create equality do not chime
        step(1'b0, 1'b1, 2'd1, 17'd104, "R9");
        step(1'b0, 1'b1, 2'd0, 17'd103, "R9");
        step(1'b0, 1'b1, 2'd0, 17'd104, "R9");
        step(1'b1, 1'b0, 2'd0, 17'd0, "R9");
        // R7 explicit disable code written by software
        step(1'b0, 1'b1, 2'd1, OFF, "R7");
        step(1'b0, 1'b1, 2'd0, 17'd65534, "R7");
        step(1'b1, 1'b0, 2'd0, 17'd0, "R7");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic        tk;
            logic        wr;
            logic [1:0]  a;
            logic [16:0] d;
            tk = ($urandom % 2) == 0;
            wr = ($urandom % 12) == 0;
            a  = 2'($urandom % 4);
            case ($urandom % 4)
                0:       d = m_alarm - 17'($urandom % 6);
                1:       d = 17'($urandom % 86400);
                2:       d = (($urandom % 2) == 0) ? OFF : LASTS;
                default: d = 17'($urandom);
            endcase
            step(tk, wr, a, d, "R6 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule